// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block sits beside an SRAM that has a nonvolatile shadow copy. It watches each completed read cycle on the 13-bit address bus and recognises a fixed, ordered run of six read addresses that software uses to ask for a nonvolatile transfer. The five leading addresses are shared. The sixth picks the command: 0x0F0F asks for a store (SRAM to nonvolatile) and 0x0F0E asks for a recall (nonvolatile to SRAM). When a run completes, the block sends a one-clock request to the store/recall controller.

A cycle-complete strobe marks the cycle whose chip-enable, write-enable, busy-pin level and address are sampled. Reads in the run return SRAM data as usual. The final read is the exception: the block withholds the data-output enable for that read, so the bus stays in high impedance. Output-enable gates the data drive but plays no part in detection.

Top module: `rsq_cmd_detect`

## Requirements
- R1: After the reads 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F arrive as consecutive counted cycles, `store_req` is high for exactly the one clock that follows the edge sampling the last read, and `recall_req` stays low.
- R2: The same five leading reads followed by 0x0F0E raise `recall_req` for exactly one clock at the same point, and `store_req` stays low.
- R3: A strobed cycle with `ce_n` high is not counted. It neither advances nor clears the run in progress, and it raises no request.
- R4: A strobed cycle with `ce_n` low and `we_n` low is a write. It cancels any run in progress, cannot itself start a run, and raises no request.
- R5: A counted read whose address is not the next expected one clears the run. If that address is 0x0000, it becomes step one of a new run.
- R6: A strobed cycle with `busy_n` low cancels any run in progress and raises no request.
- R7: `dq_oe` is high only while `ce_n` is low, `we_n` is high and `oe_n` is low. It is held low for a read that would complete a run (step six with a store or recall tail and `busy_n` high). `oe_n` has no effect on detection.
- R8: After a request the detector is idle. A further tail address alone raises nothing, and `store_req` and `recall_req` are never high together.
- R9: After reset both requests are low and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_done | input | 1 | One-clock strobe marking a completed bus cycle to sample |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; gates data drive only |
| busy_n | input | 1 | Level of the hardware store/busy pin; must be high for counted reads |
| addr | input | 13 | Address of the cycle |
| dq_oe | output | 1 | Data output drive enable for the current read |
| store_req | output | 1 | One-clock store request |
| recall_req | output | 1 | One-clock recall request |

## Verification
The hardest situations to reach from the ports are a run that is interrupted deep inside, for example at step five or six, by a stray 0x0000, a write, a busy-low cycle or a deselected cycle, and then either resumes or restarts. Uniformly random addresses almost never form even two steps in a row. The stimulus therefore follows the bench's own model of the expected next address: most cycles present that address, the tail cycle chooses store or recall at random, and interruptions are mixed in at low rates. Directed runs then place each interruption at a chosen step.

// File: rtl/rsq_pkg.sv
// Package: shared constants and types for the read-sequence command detector.
// Assumes a 13-bit address bus and a six-step run whose first five steps
// are common to both commands.
package rsq_pkg;
    localparam int ADDR_W   = 13;
    localparam int SEQ_LEN  = 6;
    localparam int PRE_LEN  = SEQ_LEN - 1;
    localparam int STEP_W   = $clog2(SEQ_LEN);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    // Ordered leading addresses; the order is the protocol itself.
    localparam addr_t LEAD_ADDR [PRE_LEN] = '{
        13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0
    };
    localparam addr_t TAIL_STORE  = 13'h0F0F;
    localparam addr_t TAIL_RECALL = 13'h0F0E;
    localparam step_t LAST_STEP   = step_t'(PRE_LEN);

    // Classification of a strobed bus cycle.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,   // no strobe, or deselected cycle
        CYC_READ  = 2'd1,   // counted read
        CYC_ABORT = 2'd2    // write or busy-low: cancels the run
    } cyc_kind_e;
endpackage

// File: rtl/rsq_cycle_qual.sv
// Module: rsq_cycle_qual
// Classifies each strobed bus cycle as ignored, a counted read or an abort.
// Assumes cyc_done is high for one clock per completed bus cycle and that
// the other inputs are stable while it is high.
module rsq_cycle_qual
    import rsq_pkg::*;
(
    input  logic      cyc_done,
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      busy_n,
    output cyc_kind_e kind
);
    // Decide what a strobed cycle means for the detector.
    always_comb begin
        if (!cyc_done || ce_n) begin
            kind = CYC_IDLE;
        end else if (!we_n || !busy_n) begin
            kind = CYC_ABORT;
        end else begin
            kind = CYC_READ;
        end
    end
endmodule

// File: rtl/rsq_step_match.sv
// Module: rsq_step_match
// Compares the cycle address with the address expected at the current step,
// and with the start address and the two tail addresses.
// Assumes the step value never exceeds LAST_STEP.
module rsq_step_match
    import rsq_pkg::*;
(
    input  step_t step,
    input  addr_t addr,
    output logic  lead_hit,
    output logic  start_hit,
    output logic  store_hit,
    output logic  recall_hit
);
    logic [PRE_LEN-1:0] lead_eq;
    logic               at_tail;

    // One comparator per leading step, selected by the current step.
    for (genvar g = 0; g < PRE_LEN; g++) begin : g_lead
        assign lead_eq[g] = (step == step_t'(g)) && (addr == LEAD_ADDR[g]);
    end

    // Reduce the per-step comparisons and evaluate the tail.
    always_comb begin
        at_tail    = (step == LAST_STEP);
        lead_hit   = |lead_eq;
        start_hit  = (addr == LEAD_ADDR[0]);
        store_hit  = at_tail && (addr == TAIL_STORE);
        recall_hit = at_tail && (addr == TAIL_RECALL);
    end
endmodule

// File: rtl/rsq_seq_fsm.sv
// Module: rsq_seq_fsm
// Holds the step count of the run and issues one-clock store/recall requests.
// Assumes at most one of store_hit/recall_hit is high, and synchronous
// active-low reset.
module rsq_seq_fsm
    import rsq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_e kind,
    input  logic      lead_hit,
    input  logic      start_hit,
    input  logic      store_hit,
    input  logic      recall_hit,
    output step_t     step,
    output logic      store_req,
    output logic      recall_req
);
    step_t step_nx;
    logic  store_nx;
    logic  recall_nx;

    // Next-step and request decision for the current cycle.
    always_comb begin
        step_nx   = step;
        store_nx  = 1'b0;
        recall_nx = 1'b0;
        unique case (kind)
            CYC_ABORT: step_nx = '0;
            CYC_READ: begin
                if (lead_hit) begin
                    step_nx = step + step_t'(1);
                end else if (store_hit) begin
                    step_nx  = '0;
                    store_nx = 1'b1;
                end else if (recall_hit) begin
                    step_nx   = '0;
                    recall_nx = 1'b1;
                end else if (start_hit) begin
                    step_nx = step_t'(1);
                end else begin
                    step_nx = '0;
                end
            end
            default: step_nx = step;
        endcase
    end

    // State and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step       <= '0;
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            step       <= step_nx;
            store_req  <= store_nx;
            recall_req <= recall_nx;
        end
    end
endmodule

// File: rtl/rsq_cmd_detect.sv
// Module: rsq_cmd_detect (top)
// Detects the six-read store/recall command run and drives the data output
// enable, withholding it on the read that completes a run.
// Assumes one cyc_done strobe per bus cycle; output-enable gates data only.
module rsq_cmd_detect
    import rsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_done,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              dq_oe,
    output logic              store_req,
    output logic              recall_req
);
    cyc_kind_e kind;
    step_t     step;
    logic      lead_hit;
    logic      start_hit;
    logic      store_hit;
    logic      recall_hit;

    rsq_cycle_qual u_qual (
        .cyc_done (cyc_done),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .busy_n   (busy_n),
        .kind     (kind)
    );

    rsq_step_match u_match (
        .step       (step),
        .addr       (addr),
        .lead_hit   (lead_hit),
        .start_hit  (start_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    rsq_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .lead_hit   (lead_hit),
        .start_hit  (start_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit),
        .step       (step),
        .store_req  (store_req),
        .recall_req (recall_req)
    );

    // Data drive: normal read, except the read that finishes a run.
    always_comb begin
        dq_oe = !ce_n && we_n && !oe_n
                && !(busy_n && (store_hit || recall_hit));
    end
endmodule

// File: rtl/rsq_cmd_detect_chk.sv
// Module: rsq_cmd_detect_chk
// Port-level temporal checks for rsq_cmd_detect, attached with bind.
module rsq_cmd_detect_chk
    import rsq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_done,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              busy_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic              store_req,
    input logic              recall_req
);
    // R1
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);
    // R1
    store_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> $past(cyc_done && !ce_n && we_n && busy_n
                                   && addr == TAIL_STORE));
    // R2
    recall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);
    // R2
    recall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_req) |-> $past(cyc_done && !ce_n && we_n && busy_n
                                    && addr == TAIL_RECALL));
    // R3
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && ce_n) |=> !(store_req || recall_req));
    // R4
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !we_n) |=> !(store_req || recall_req));
    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !busy_n) |=> !(store_req || recall_req));
    // R7
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !we_n || oe_n) |-> !dq_oe);
    // R8
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));
endmodule

bind rsq_cmd_detect rsq_cmd_detect_chk u_chk (.*);

// File: tb/rsq_cmd_detect_tb_top.sv
`timescale 1ns/1ps
module rsq_cmd_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_done = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        busy_n = 1'b1;
    logic [12:0] addr = '0;
    logic        dq_oe;
    logic        store_req;
    logic        recall_req;

    int checks = 0;
    int fails  = 0;
    int mstep  = 0;     // bench model of the run position
    bit done   = 0;

    always #2.5 clk = ~clk;

    rsq_cmd_detect dut_i (.*);

    function automatic logic [12:0] lead_of(int i);
        case (i)
            0: return 13'h0000;
            1: return 13'h1555;
            2: return 13'h0AAA;
            3: return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    // Expected drive enable for the cycle now on the bus.
    function automatic bit exp_oe(bit c, bit w, bit o, bit b, logic [12:0] a);
        bit fin = (mstep == 5) && b && (a == 13'h0F0F || a == 13'h0F0E);
        return !c && w && !o && !fin;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobed cycle: check drive, advance the model, check requests.
    task automatic cyc(bit c, bit w, bit o, bit b, logic [12:0] a, string req);
        int es = 0, er = 0;
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; busy_n = b; addr = a; cyc_done = 1'b1;
        #1;
        check({req, " R8 idle reqs"}, {store_req, recall_req}, 0);
        check({req, " R7 dq_oe"}, dq_oe, exp_oe(c, w, o, b, a));
        if (!c) begin
            if (!w || !b) mstep = 0;
            else if (mstep < 5 && a == lead_of(mstep)) mstep++;
            else if (mstep == 5 && a == 13'h0F0F) begin es = 1; mstep = 0; end
            else if (mstep == 5 && a == 13'h0F0E) begin er = 1; mstep = 0; end
            else mstep = (a == 13'h0000) ? 1 : 0;
        end
        @(negedge clk);
        cyc_done = 1'b0;
        #1;
        check({req, " store_req"}, store_req, es);
        check({req, " recall_req"}, recall_req, er);
    endtask

    task automatic rd(logic [12:0] a, string req);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, a, req);
    endtask

    task automatic lead5(string req);
        for (int i = 0; i < 5; i++) rd(lead_of(i), req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EC0);
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset store", store_req, 0);
        check("R9 reset recall", recall_req, 0);
        rst_n = 1'b1;
        // R1 plain store run, R8 tail alone afterwards
        lead5("R1"); rd(13'h0F0F, "R1");
        rd(13'h0F0F, "R8 lone tail");
        // R2 recall run, output-enable high throughout (R7)
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, lead_of(i), "R7 oe high");
        cyc(0, 1, 1, 1, 13'h0F0E, "R2");
        // R3 deselected cycles inside a run do not disturb it
        rd(13'h0000, "R3"); rd(13'h1555, "R3");
        cyc(1, 1, 0, 1, 13'h1234, "R3"); cyc(1, 0, 0, 1, 13'h0000, "R3");
        rd(13'h0AAA, "R3"); rd(13'h1FFF, "R3"); rd(13'h10F0, "R3");
        cyc(1, 1, 0, 1, 13'h0F0F, "R3"); rd(13'h0F0F, "R3");
        // R4 write at step five cancels; a write to 0x0000 does not start
        for (int i = 0; i < 4; i++) rd(lead_of(i), "R4");
        cyc(0, 0, 1, 1, 13'h10F0, "R4"); rd(13'h10F0, "R4"); rd(13'h0F0F, "R4");
        cyc(0, 0, 1, 1, 13'h0000, "R4"); lead5("R4"); rd(13'h0F0E, "R4");
        // R5 stray 0x0000 at the tail restarts; wrong tail clears
        lead5("R5"); rd(13'h0000, "R5");
        for (int i = 1; i < 5; i++) rd(lead_of(i), "R5");
        rd(13'h0F0F, "R5");
        lead5("R5"); rd(13'h0F0D, "R5"); rd(13'h0F0F, "R5");
        // R6 busy low at the tail cancels
        lead5("R6"); cyc(0, 1, 0, 0, 13'h0F0F, "R6"); rd(13'h0F0F, "R6");
        // Random cycles biased along the expected run
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(99);
            logic [12:0] a;
            if (r < 70) a = (mstep < 5) ? lead_of(mstep)
                          : ($urandom_range(1) ? 13'h0F0F : 13'h0F0E);
            else if (r < 80) a = 13'h0000;
            else a = 13'($urandom);
            cyc($urandom_range(99) < 8, $urandom_range(99) >= 4,
                1'($urandom), $urandom_range(99) >= 4, a, "R1 R2 R5 random");
        end
        finish_run();
    end
endmodule